// File: doc/BRIEF.md
# Snooping Bus Agent Controller

This block is the bus-facing controller of one cache that sits on a shared, atomic snooping bus and keeps its lines in the four MESI states. It has two sides that run independently. The requester side takes a miss from the core, asks the arbiter for the bus and, once granted, places a read (BusRd) or a read-for-ownership (BusRdX) on it. It then waits for the wired-OR snoop-valid line to drop, samples the wired-OR shared and dirty lines at that moment, waits for the data-ready handshake, and installs the line.

The responder side watches grants given to other agents. It raises its snoop-valid contribution on the cycle after such a grant and looks up its small directly indexed tag array over a fixed number of cycles. It then drives its shared and dirty contributions, and only after that drops snoop-valid. Each wired-OR line is modelled as an output-enable from this agent and a resolved input from the system. The responder keeps working while the requester's own request is still waiting for the arbiter, so two agents that each wait for the bus cannot block each other.

Top module: `snoop_agent`

## Requirements
- R1: While `bus_req` is high and `bus_gnt` is low, `bus_req` stays high on the next cycle and `bus_cmd_vld` is low; `bus_cmd_vld` is high only in a cycle with `bus_gnt` high, together with the held command (`bus_cmd_out` 0 = BusRd, 1 = BusRdX) and address.
- R2: A cycle with `other_gnt` high, while the responder is idle, gives `sv_oe` high on the next cycle. `sv_oe` then stays high for exactly LOOKUP_LAT+1 cycles, whatever the lookup result.
- R3: `sh_oe` and `dt_oe` take their final values in the last cycle in which `sv_oe` is high. They stay unchanged when `sv_oe` falls, and return to 0 in the cycle after `xfer_done`.
- R4: The requester samples `sh_in` and `dt_in` only in the first cycle after its grant in which `sv_in` reads 0. Values these lines show earlier are ignored. `core_done` is high in the cycle of `xfer_done` after that sample.
- R5: A completed BusRd installs the line as Shared (state code 1) if `sh_in` or `dt_in` was sampled high, otherwise as Exclusive (code 2).
- R6: A completed BusRdX installs the line as Modified (code 3) regardless of the sampled lines.
- R7: A snoop that hits a Modified line drives `dt_oe`=1 and `sh_oe`=0. A BusRd then leaves the line Shared, and a BusRdX leaves it Invalid (code 0).
- R8: A snoop that hits an Exclusive or Shared line drives `sh_oe`=1 on BusRd and leaves the line Shared. On BusRdX it drives neither line and leaves the line Invalid.
- R9: A snoop whose tag misses, or that hits an Invalid entry, drives neither `sh_oe` nor `dt_oe` and changes no line state.
- R10: Snoops are serviced with the R2 timing while the agent's own request is pending and not yet granted, and that request stays pending throughout.
- R11: After reset all lines read Invalid on `core_state`, and `bus_req`, `bus_cmd_vld`, `core_done`, `sv_oe`, `sh_oe` and `dt_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core miss request, held until `core_done` |
| core_rdx | input | 1 | 1 = read for ownership, 0 = read |
| core_addr | input | AW | Miss address; also the address of the state probe |
| core_done | output | 1 | Line installed this cycle |
| core_state | output | 2 | State of the line at `core_addr` (0 I, 1 S, 2 E, 3 M) |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant to this agent |
| bus_cmd_vld | output | 1 | Own command on the bus this cycle |
| bus_cmd_out | output | 1 | Own command code |
| bus_addr_out | output | AW | Own command address |
| other_gnt | input | 1 | Another agent granted; its command is on the bus |
| bus_cmd_in | input | 1 | Foreign command code |
| bus_addr_in | input | AW | Foreign command address |
| xfer_done | input | 1 | Data-ready handshake ending the current bus transaction |
| sv_oe | output | 1 | This agent's snoop-valid contribution |
| sh_oe | output | 1 | This agent's shared contribution |
| dt_oe | output | 1 | This agent's dirty contribution |
| sv_in | input | 1 | Resolved wired-OR snoop-valid |
| sh_in | input | 1 | Resolved wired-OR shared |
| dt_in | input | 1 | Resolved wired-OR dirty |

## Verification
The requester is driven with reads and ownership reads in which the other responders hold snoop-valid for zero to three cycles. Some of these runs flash the shared line while snoop-valid is still high and then clear it. These patterns show whether the agent waits for the slowest responder and samples at the release instead of earlier. Final line patterns of none, shared only, and dirty only separate the Exclusive, Shared and Modified installs. Responder snoops cover every line state with both commands, including a tag miss, an Invalid hit, and a snoop that arrives while the agent's own request is still waiting for the arbiter.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
// Shared types of the snooping agent: line states and bus command codes.
package snoop_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic {
        CMD_RD  = 1'b0,
        CMD_RDX = 1'b1
    } bcmd_t;
endpackage

// File: rtl/snoop_tags.sv
`timescale 1ns/1ps
// Directly indexed tag and state array.
// Two combinational read ports (core probe, snoop lookup), one write port.
// Assumes the caller never writes from two sources in one cycle.
module snoop_tags #(
    parameter int AW    = 8,
    parameter int IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       pa_addr,
    output snoop_pkg::mesi_t    pa_state,
    input  logic [AW-1:0]       sa_addr,
    output snoop_pkg::mesi_t    sa_state,
    input  logic                we,
    input  logic [AW-1:0]       wa_addr,
    input  snoop_pkg::mesi_t    wstate
);
    import snoop_pkg::*;

    localparam int NSETS = 1 << IDX_W;
    localparam int TW    = AW - IDX_W;

    logic [TW-1:0] tag_q [NSETS];
    mesi_t         st_q  [NSETS];

    // Write port: all entries Invalid on reset, else install tag and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSETS; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else if (we) begin
            tag_q[wa_addr[IDX_W-1:0]] <= wa_addr[AW-1:IDX_W];
            st_q[wa_addr[IDX_W-1:0]]  <= wstate;
        end
    end

    // Read ports: a tag mismatch reads as Invalid.
    assign pa_state = (tag_q[pa_addr[IDX_W-1:0]] == pa_addr[AW-1:IDX_W])
                      ? st_q[pa_addr[IDX_W-1:0]] : ST_I;
    assign sa_state = (tag_q[sa_addr[IDX_W-1:0]] == sa_addr[AW-1:IDX_W])
                      ? st_q[sa_addr[IDX_W-1:0]] : ST_I;
endmodule

// File: rtl/snoop_responder.sv
`timescale 1ns/1ps
// Responder FSM: answers commands issued by other agents.
// Raises snoop-valid the cycle after a foreign grant, spends LAT cycles on
// the lookup, drives shared/dirty with snoop-valid still high for one cycle,
// then drops snoop-valid and holds shared/dirty until the transfer ends.
// Assumes an atomic bus: no new foreign grant before xfer_done.
module snoop_responder #(
    parameter int AW  = 8,
    parameter int LAT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                other_gnt,
    input  logic                cmd_in,
    input  logic [AW-1:0]       addr_in,
    input  logic                xfer_done,
    output logic [AW-1:0]       look_addr,
    input  snoop_pkg::mesi_t    look_state,
    output logic                upd_en,
    output snoop_pkg::mesi_t    upd_state,
    output logic                sv_oe,
    output logic                sh_oe,
    output logic                dt_oe
);
    import snoop_pkg::*;

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef enum logic [1:0] {R_IDLE, R_LOOK, R_DRIVE, R_HOLD} rsp_st_t;

    rsp_st_t        st_q;
    logic [CW-1:0]  cnt_q;
    bcmd_t          cmd_q;
    logic [AW-1:0]  addr_q;
    logic           sh_q, dt_q;

    // Sequencing of one snoop: capture, count lookup, drive, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= R_IDLE;
            cnt_q  <= '0;
            cmd_q  <= CMD_RD;
            addr_q <= '0;
            sh_q   <= 1'b0;
            dt_q   <= 1'b0;
        end else begin
            case (st_q)
                R_IDLE: if (other_gnt) begin
                    st_q   <= R_LOOK;
                    cnt_q  <= '0;
                    cmd_q  <= bcmd_t'(cmd_in);
                    addr_q <= addr_in;
                end
                R_LOOK: begin
                    if (cnt_q == CW'(LAT-1)) begin
                        st_q <= R_DRIVE;
                        dt_q <= (look_state == ST_M);
                        sh_q <= (look_state == ST_E || look_state == ST_S)
                                && (cmd_q == CMD_RD);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                R_DRIVE: st_q <= R_HOLD;
                R_HOLD: if (xfer_done) begin
                    st_q <= R_IDLE;
                    sh_q <= 1'b0;
                    dt_q <= 1'b0;
                end
                default: st_q <= R_IDLE;
            endcase
        end
    end

    // Outputs decoded from the registered phase.
    assign look_addr = addr_q;
    assign sv_oe     = (st_q == R_LOOK) || (st_q == R_DRIVE);
    assign sh_oe     = sh_q && (st_q == R_DRIVE || st_q == R_HOLD);
    assign dt_oe     = dt_q && (st_q == R_DRIVE || st_q == R_HOLD);

    // State change of a hit line, applied while leaving the drive phase.
    assign upd_en    = (st_q == R_DRIVE) && (look_state != ST_I);
    assign upd_state = (cmd_q == CMD_RDX) ? ST_I : ST_S;

    // R2: snoop-valid follows a foreign grant by one cycle.
    a_r2_sv_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (other_gnt && st_q == R_IDLE) |=> sv_oe);

    // R3: shared/dirty are already final when snoop-valid falls.
    a_r3_final_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sv_oe) |-> ($stable(sh_oe) && $stable(dt_oe)));

    // R9: an Invalid or missing line drives neither response line.
    a_r9_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_DRIVE && look_state == ST_I) |-> (!sh_oe && !dt_oe));
endmodule

// File: rtl/snoop_requester.sv
`timescale 1ns/1ps
// Requester FSM: turns a core miss into a bus command.
// Requests the bus, issues in the grant cycle, waits for the resolved
// snoop-valid line to read 0, samples shared/dirty, and installs the line
// on the data-ready handshake.
// Assumes core_req and its fields are held until core_done.
module snoop_requester #(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_req,
    input  logic                core_rdx,
    input  logic [AW-1:0]       core_addr,
    output logic                core_done,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic                bus_cmd_vld,
    output logic                bus_cmd_out,
    output logic [AW-1:0]       bus_addr_out,
    input  logic                sv_in,
    input  logic                sh_in,
    input  logic                dt_in,
    input  logic                xfer_done,
    output logic                we,
    output logic [AW-1:0]       waddr,
    output snoop_pkg::mesi_t    wstate
);
    import snoop_pkg::*;

    typedef enum logic [1:0] {Q_IDLE, Q_REQ, Q_SNOOP, Q_WAITD} req_st_t;

    req_st_t        st_q;
    bcmd_t          cmd_q;
    logic [AW-1:0]  addr_q;
    logic           shared_q;

    // Request sequencing from capture to install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= Q_IDLE;
            cmd_q    <= CMD_RD;
            addr_q   <= '0;
            shared_q <= 1'b0;
        end else begin
            case (st_q)
                Q_IDLE: if (core_req) begin
                    st_q   <= Q_REQ;
                    cmd_q  <= bcmd_t'(core_rdx);
                    addr_q <= core_addr;
                end
                Q_REQ:   if (bus_gnt) st_q <= Q_SNOOP;
                Q_SNOOP: if (!sv_in) begin
                    st_q     <= Q_WAITD;
                    shared_q <= sh_in || dt_in;
                end
                Q_WAITD: if (xfer_done) st_q <= Q_IDLE;
                default: st_q <= Q_IDLE;
            endcase
        end
    end

    // Bus-side outputs and install decode.
    assign bus_req      = (st_q == Q_REQ);
    assign bus_cmd_vld  = (st_q == Q_REQ) && bus_gnt;
    assign bus_cmd_out  = cmd_q;
    assign bus_addr_out = addr_q;
    assign core_done    = (st_q == Q_WAITD) && xfer_done;
    assign we           = core_done;
    assign waddr        = addr_q;
    assign wstate       = (cmd_q == CMD_RDX) ? ST_M : (shared_q ? ST_S : ST_E);

    // R1: a pending request is not withdrawn before its grant.
    a_r1_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R4: completion is only signalled once every responder has released.
    a_r4_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> !sv_in);
endmodule

// File: rtl/snoop_agent.sv
`timescale 1ns/1ps
// Bus agent of one cache on an atomic MESI snooping bus.
// Joins the requester, the responder and the tag array. The responder runs
// independently of the requester, so snoops are served while a request
// waits for its grant. Wired-OR lines appear as per-agent enables (outputs)
// and resolved values (inputs).
module snoop_agent #(
    parameter int AW         = 8,
    parameter int IDX_W      = 2,
    parameter int LOOKUP_LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_req,
    input  logic            core_rdx,
    input  logic [AW-1:0]   core_addr,
    output logic            core_done,
    output logic [1:0]      core_state,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_cmd_vld,
    output logic            bus_cmd_out,
    output logic [AW-1:0]   bus_addr_out,
    input  logic            other_gnt,
    input  logic            bus_cmd_in,
    input  logic [AW-1:0]   bus_addr_in,
    input  logic            xfer_done,
    output logic            sv_oe,
    output logic            sh_oe,
    output logic            dt_oe,
    input  logic            sv_in,
    input  logic            sh_in,
    input  logic            dt_in
);
    import snoop_pkg::*;

    logic           q_we, r_we;
    logic [AW-1:0]  q_waddr, r_addr;
    mesi_t          q_wstate, r_wstate, probe_st, snoop_st;
    logic           t_we;
    logic [AW-1:0]  t_waddr;
    mesi_t          t_wstate;

    snoop_requester #(.AW(AW)) req_i (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_rdx(core_rdx), .core_addr(core_addr),
        .core_done(core_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_vld(bus_cmd_vld),
        .bus_cmd_out(bus_cmd_out), .bus_addr_out(bus_addr_out),
        .sv_in(sv_in), .sh_in(sh_in), .dt_in(dt_in), .xfer_done(xfer_done),
        .we(q_we), .waddr(q_waddr), .wstate(q_wstate)
    );

    snoop_responder #(.AW(AW), .LAT(LOOKUP_LAT)) rsp_i (
        .clk(clk), .rst_n(rst_n),
        .other_gnt(other_gnt), .cmd_in(bus_cmd_in), .addr_in(bus_addr_in),
        .xfer_done(xfer_done),
        .look_addr(r_addr), .look_state(snoop_st),
        .upd_en(r_we), .upd_state(r_wstate),
        .sv_oe(sv_oe), .sh_oe(sh_oe), .dt_oe(dt_oe)
    );

    // Single tag write port; the atomic bus keeps both sides apart in time.
    always_comb begin
        t_we     = q_we || r_we;
        t_waddr  = q_we ? q_waddr  : r_addr;
        t_wstate = q_we ? q_wstate : r_wstate;
    end

    snoop_tags #(.AW(AW), .IDX_W(IDX_W)) tags_i (
        .clk(clk), .rst_n(rst_n),
        .pa_addr(core_addr), .pa_state(probe_st),
        .sa_addr(r_addr), .sa_state(snoop_st),
        .we(t_we), .wa_addr(t_waddr), .wstate(t_wstate)
    );

    assign core_state = probe_st;

    // Parameter range of the lookup latency.
    initial begin
        a_r2_lat_range: assert (LOOKUP_LAT >= 1 && LOOKUP_LAT <= 4);
    end
endmodule

// File: tb/snoop_agent_tb_top.sv
`timescale 1ns/1ps
module snoop_agent_tb_top;
    localparam int AW  = 8;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 0, core_rdx = 0, bus_gnt = 0, other_gnt = 0;
    logic bus_cmd_in = 0, xfer_done = 0;
    logic [AW-1:0] core_addr = '0, bus_addr_in = '0;
    logic ext_sv = 0, ext_sh = 0, ext_dt = 0;
    logic core_done, bus_req, bus_cmd_vld, bus_cmd_out;
    logic [1:0] core_state;
    logic [AW-1:0] bus_addr_out;
    logic sv_oe, sh_oe, dt_oe;
    logic sv_in, sh_in, dt_in;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    // Wired-OR resolution of this agent with the modelled other agents.
    assign sv_in = sv_oe | ext_sv;
    assign sh_in = sh_oe | ext_sh;
    assign dt_in = dt_oe | ext_dt;

    snoop_agent #(.AW(AW), .IDX_W(2), .LOOKUP_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_rdx(core_rdx), .core_addr(core_addr),
        .core_done(core_done), .core_state(core_state),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_vld(bus_cmd_vld),
        .bus_cmd_out(bus_cmd_out), .bus_addr_out(bus_addr_out),
        .other_gnt(other_gnt), .bus_cmd_in(bus_cmd_in), .bus_addr_in(bus_addr_in),
        .xfer_done(xfer_done),
        .sv_oe(sv_oe), .sh_oe(sh_oe), .dt_oe(dt_oe),
        .sv_in(sv_in), .sh_in(sh_in), .dt_in(dt_in)
    );

    // Vector: [15] rdx, [14:7] addr, [6] shared while valid high,
    // [5] final shared, [4] final dirty, [3:2] valid-high cycles, [1:0] expected state.
    localparam logic [15:0] VEC [0:5] = '{
        {1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 2'd3, 2'd2},
        {1'b0, 8'h21, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1},
        {1'b1, 8'h32, 1'b0, 1'b1, 1'b0, 2'd2, 2'd3},
        {1'b0, 8'h43, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1},
        {1'b1, 8'h14, 1'b0, 1'b0, 1'b1, 2'd2, 2'd3},
        {1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 2'd3, 2'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic req_start(input logic rdx, input logic [AW-1:0] addr);
        @(negedge clk);
        core_req = 1; core_rdx = rdx; core_addr = addr;
        @(negedge clk);
        chk("R1 bus_req raised", bus_req, 1);
        chk("R1 no command before grant", bus_cmd_vld, 0);
    endtask

    task automatic req_finish(input logic rdx, input logic [AW-1:0] addr,
                              input logic early, input logic fsh, input logic fdt,
                              input int d, input int exp);
        bus_gnt = 1;
        #1;
        chk("R1 command in grant cycle", bus_cmd_vld, 1);
        chk("R1 command code", bus_cmd_out, rdx);
        chk("R1 command address", bus_addr_out, addr);
        @(negedge clk);
        bus_gnt = 0;
        ext_sv = (d != 0);
        ext_sh = (d != 0) ? early : fsh;
        ext_dt = (d != 0) ? 1'b0 : fdt;
        repeat (d) @(negedge clk);
        ext_sv = 0; ext_sh = fsh; ext_dt = fdt;
        @(negedge clk);
        ext_sh = 0; ext_dt = 0; xfer_done = 1;
        #1;
        chk("R4 done on handshake after release", core_done, 1);
        @(negedge clk);
        xfer_done = 0; core_req = 0; core_addr = addr;
        #1;
        chk(rdx ? "R6 install state" : "R5 install state", core_state, exp);
    endtask

    task automatic snoop(input string req, input logic cmd, input logic [AW-1:0] addr,
                         input int esh, input int edt,
                         input logic [AW-1:0] paddr, input int est);
        int n;
        @(negedge clk);
        other_gnt = 1; bus_cmd_in = cmd; bus_addr_in = addr;
        @(negedge clk);
        other_gnt = 0;
        chk({req, " R2 valid next cycle"}, sv_oe, 1);
        n = 0;
        while (sv_oe && n < 10) begin
            n++;
            @(negedge clk);
        end
        chk({req, " R2 valid width"}, n, LAT + 1);
        chk({req, " R3 shared held at release"}, sh_oe, esh);
        chk({req, " R3 dirty held at release"}, dt_oe, edt);
        @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        chk({req, " R3 lines released"}, sh_oe | dt_oe, 0);
        core_addr = paddr;
        #1;
        chk({req, " state after snoop"}, core_state, est);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state.
        chk("R11 bus_req", bus_req, 0);
        chk("R11 outputs", {core_done, bus_cmd_vld, sv_oe, sh_oe, dt_oe}, 0);
        for (int i = 0; i < 4; i++) begin
            core_addr = 8'(i * 17);
            #1;
            chk("R11 line invalid", core_state, 0);
        end

        // Requester vectors: R4 R5 R6.
        for (int v = 0; v < 6; v++) begin
            logic [15:0] e;
            e = VEC[v];
            req_start(e[15], e[14:7]);
            req_finish(e[15], e[14:7], e[6], e[5], e[4], int'(e[3:2]), int'(e[1:0]));
        end

        // Responder: R7 modified on read, R8 shared/exclusive, R9 misses.
        snoop("R7", 1'b0, 8'h32, 0, 1, 8'h32, 1);
        snoop("R8", 1'b1, 8'h21, 0, 0, 8'h21, 0);
        snoop("R8", 1'b0, 8'h08, 1, 0, 8'h08, 1);
        snoop("R9", 1'b0, 8'h42, 0, 0, 8'h32, 1);

        // R10: snoop served while own request waits for the arbiter.
        req_start(1'b1, 8'h43);
        snoop("R10", 1'b0, 8'h08, 1, 0, 8'h08, 1);
        chk("R10 request still pending", bus_req, 1);
        core_addr = 8'h43;
        req_finish(1'b1, 8'h43, 1'b0, 1'b0, 1'b0, 2, 3);

        snoop("R7", 1'b1, 8'h43, 0, 1, 8'h43, 0);
        snoop("R9", 1'b0, 8'h21, 0, 0, 8'h21, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule